// File: doc/BRIEF.md
# Watchdog Timer with Reset Routing

This block is a countdown watchdog behind a small 32-bit word-addressed register bus. Software programs a reload value, arms the counter, and must keep writing a fixed 16-bit restart key before the count runs out. The count steps down once per tick. The tick comes from one of two externally supplied strobes, and a control bit picks which one.

When the count reaches zero, the block sets a sticky timeout flag. If resets are armed, it also emits a reset pulse of programmable length. The pulse goes to exactly one of three reset scopes (system, whole chip, processor only). In masked mode it goes instead to the set of individual peripheral reset lines picked by a mask register. A control bit can also ask for an alternate boot source. The block records that request as a status flag only.

Register words, by index: 0 live count (read only), 1 reload value, 2 restart key (reads 0), 3 control, 4 timeout status, 5 status clear (reads 0), 6 reset pulse width, 7 peripheral reset mask.

Top module: `wdog_rstroute`

## Requirements
- R1: After reset the live count, control, status, width and mask registers read 0, and every reset output is low.
- R2: A write of exactly 0x00004755 to word 2 copies the reload value (word 1) into the live count. Any other value written to word 2 leaves the count unchanged.
- R3: Writing word 1 does not change the live count until the next valid restart write.
- R4: While control bit 0 is 1, the count drops by one on each selected tick. While it is 0, the count holds.
- R5: Control bit 4 = 1 selects the `tick_1m` strobe as the count tick; bit 4 = 0 selects `tick_base`. The strobe that is not selected has no effect.
- R6: When a tick takes the count from 1 to 0, status bit 0 is set and the count stays at 0. Status bit 0 stays set until a write to word 5 with bit 0 = 1. A write to word 5 with bit 0 = 0 has no effect.
- R7: Status bit 1 is set at expiry if control bit 7 is 1 at that moment. It is cleared together with bit 0.
- R8: With control bit 1 = 0, an expiry drives no reset output.
- R9: With control bit 1 = 1, control bits 6:5 pick the reset scope: 0 pulses `rst_soc`, 1 pulses `rst_chip`, 2 pulses `rst_cpu`. At most one scope output is high at any time.
- R10: Control bits 6:5 = 3 pulse `rst_periph` with the value of the mask register (bits 25:0), and all scope outputs stay low.
- R11: Reset outputs rise at the expiry edge and fall on the Nth selected tick after it, where N is word 6. A width of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 3 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the word at `bus_addr` |
| tick_base | input | 1 | Default count tick strobe |
| tick_1m | input | 1 | Fixed 1 MHz count tick strobe |
| rst_soc | output | 1 | System-scope reset pulse |
| rst_chip | output | 1 | Whole-chip reset pulse |
| rst_cpu | output | 1 | Processor-only reset pulse |
| rst_periph | output | 26 | Per-peripheral reset pulses |

## Verification
The bench writes near-miss restart keys and expects the count unchanged. A design that compares only part of the word would reload on them. It rewrites the reload value mid-count and expects the live count to keep going. A design that copies the value straight through would jump to the new value. It strobes the tick that is not selected and expects nothing to happen. It also clears status with a zero bit, where a design that clears on any write would drop the flag. Pulse length is counted tick by tick for widths 0 and 3, which exposes off-by-one pulse lengths. Masked mode is checked for leaks onto the scope outputs.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int BUS_W = 32;
  localparam int ADDR_W = 3;
  localparam logic [BUS_W-1:0] KICK_KEY = 32'h0000_4755;

  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd0;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd1;
  localparam logic [ADDR_W-1:0] A_KICK   = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd4;
  localparam logic [ADDR_W-1:0] A_CLR    = 3'd5;
  localparam logic [ADDR_W-1:0] A_WIDTH  = 3'd6;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd7;

  localparam int CB_RUN   = 0;
  localparam int CB_ARM   = 1;
  localparam int CB_FAST  = 4;
  localparam int CB_MODE  = 5;
  localparam int CB_ALTBT = 7;

  typedef enum logic [1:0] {
    SCOPE_SOC  = 2'd0,
    SCOPE_CHIP = 2'd1,
    SCOPE_CPU  = 2'd2,
    SCOPE_MASK = 2'd3
  } scope_e;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PW_W  = 8,
  parameter int NPER  = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              expire,
  output logic [BUS_W-1:0]  rdata,
  output logic              kick,
  output logic [CNT_W-1:0]  reload,
  output logic [7:0]        ctrl,
  output logic [PW_W-1:0]   width,
  output logic [NPER-1:0]   mask
);
  logic [1:0] stat_q;
  logic       clr_hit;

  assign kick    = wr && addr == A_KICK && wdata == KICK_KEY;
  assign clr_hit = wr && addr == A_CLR && wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      reload <= '0;
      ctrl   <= '0;
      width  <= '0;
      mask   <= '0;
    end else if (wr) begin
      case (addr)
        A_RELOAD: reload <= wdata[CNT_W-1:0];
        A_CTRL:   ctrl   <= wdata[7:0];
        A_WIDTH:  width  <= wdata[PW_W-1:0];
        A_MASK:   mask   <= wdata[NPER-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
    end else if (expire) begin
      stat_q[0] <= 1'b1;
      stat_q[1] <= stat_q[1] | ctrl[CB_ALTBT];
    end else if (clr_hit) begin
      stat_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        A_COUNT:  rdata <= BUS_W'(count);
        A_RELOAD: rdata <= BUS_W'(reload);
        A_CTRL:   rdata <= BUS_W'(ctrl);
        A_STAT:   rdata <= BUS_W'(stat_q);
        A_WIDTH:  rdata <= BUS_W'(width);
        A_MASK:   rdata <= BUS_W'(mask);
        default:  rdata <= '0;
      endcase
    end
  end

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (stat_q[0] && !clr_hit) |=> stat_q[0]);
  assert_clear_works_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_hit && !expire) |=> stat_q == 2'b00);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] reload,
  input  logic             run,
  input  logic             step,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic dec;

  assign dec    = run && step && count != '0;
  assign expire = !load && dec && count == ONE;

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= reload;
    else if (dec)  count <= count - ONE;
  end

  assert_no_rise_R2: assert property (@(posedge clk) disable iff (rst)
    !load |=> count <= $past(count));
  assert_hold_off_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && !run) |=> $stable(count));
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse
  import wdog_pkg::*;
#(
  parameter int PW_W = 8,
  parameter int NPER = 26
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            expire,
  input  logic            arm,
  input  logic [1:0]      mode,
  input  logic [PW_W-1:0] width,
  input  logic [NPER-1:0] mask,
  input  logic            step,
  output logic            o_soc,
  output logic            o_chip,
  output logic            o_cpu,
  output logic [NPER-1:0] o_per
);
  localparam logic [PW_W-1:0] ONE = PW_W'(1);
  logic            active;
  logic [PW_W-1:0] remain;
  logic            fire, stop;
  scope_e          sel;

  assign sel  = scope_e'(mode);
  assign fire = expire && arm;
  assign stop = !fire && active && step && remain <= ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      remain <= '0;
    end else if (fire) begin
      active <= 1'b1;
      remain <= (width == '0) ? ONE : width;
    end else if (stop) begin
      active <= 1'b0;
      remain <= '0;
    end else if (active && step) begin
      remain <= remain - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || stop) begin
      o_soc  <= 1'b0;
      o_chip <= 1'b0;
      o_cpu  <= 1'b0;
    end else if (fire) begin
      o_soc  <= sel == SCOPE_SOC;
      o_chip <= sel == SCOPE_CHIP;
      o_cpu  <= sel == SCOPE_CPU;
    end
  end

  for (genvar i = 0; i < NPER; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst || stop)  o_per[i] <= 1'b0;
      else if (fire)    o_per[i] <= (sel == SCOPE_MASK) && mask[i];
    end
  end

  assert_scope_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({o_soc, o_chip, o_cpu}));
  assert_mask_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    (|o_per) |-> !(o_soc || o_chip || o_cpu));
  assert_quiet_unarmed_R8: assert property (@(posedge clk) disable iff (rst)
    (expire && !arm && !active) |=> !(o_soc || o_chip || o_cpu || (|o_per)));
  assert_outputs_need_active_R11: assert property (@(posedge clk) disable iff (rst)
    (o_soc || o_chip || o_cpu || (|o_per)) |-> active);
endmodule

// File: rtl/wdog_rstroute.sv
module wdog_rstroute
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PW_W  = 8,
  parameter int NPER  = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              tick_base,
  input  logic              tick_1m,
  output logic              rst_soc,
  output logic              rst_chip,
  output logic              rst_cpu,
  output logic [NPER-1:0]   rst_periph
);
  logic             kick, expire, step;
  logic [CNT_W-1:0] count, reload;
  logic [7:0]       ctrl;
  logic [PW_W-1:0]  width;
  logic [NPER-1:0]  mask;

  assign step = ctrl[CB_FAST] ? tick_1m : tick_base;

  wdog_regs #(.CNT_W(CNT_W), .PW_W(PW_W), .NPER(NPER)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .count(count), .expire(expire), .rdata(bus_rdata), .kick(kick),
    .reload(reload), .ctrl(ctrl), .width(width), .mask(mask)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(kick), .reload(reload),
    .run(ctrl[CB_RUN]), .step(step), .count(count), .expire(expire)
  );

  wdog_pulse #(.PW_W(PW_W), .NPER(NPER)) u_pulse (
    .clk(clk), .rst(rst), .expire(expire), .arm(ctrl[CB_ARM]),
    .mode(ctrl[CB_MODE+1:CB_MODE]), .width(width), .mask(mask), .step(step),
    .o_soc(rst_soc), .o_chip(rst_chip), .o_cpu(rst_cpu), .o_per(rst_periph)
  );
endmodule

// File: tb/test_wdog_rstroute.sv
module test_wdog_rstroute;
  logic        clk = 0, rst = 1;
  logic        bus_wr = 0;
  logic [2:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        tick_base = 0, tick_1m = 0;
  logic        rst_soc, rst_chip, rst_cpu;
  logic [25:0] rst_periph;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wdog_rstroute i_wdog_rstroute (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_base(tick_base),
    .tick_1m(tick_1m), .rst_soc(rst_soc), .rst_chip(rst_chip),
    .rst_cpu(rst_cpu), .rst_periph(rst_periph)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; bus_wr = 0; tick_base = 0; tick_1m = 0;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic tb_tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_base = 1;
      @(negedge clk); tick_base = 0;
    end
  endtask

  task automatic tm_tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1m = 1;
      @(negedge clk); tick_1m = 0;
    end
  endtask

  function automatic logic [31:0] outs();
    return {3'b0, rst_soc, rst_chip, rst_cpu, rst_periph};
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d); chk("R1 reg reset", d, 0);
    end
    chk("R1 outputs reset", outs(), 0);
  endtask

  task automatic t_key();
    logic [31:0] d;
    do_reset();
    wr(1, 100);
    wr(2, 32'h0000_4754); rd(0, d); chk("R2 wrong key ignored", d, 0);
    wr(2, 32'h0001_4755); rd(0, d); chk("R2 upper bits ignored key", d, 0);
    wr(2, 32'h0000_4755); rd(0, d); chk("R2 key loads", d, 100);
  endtask

  task automatic t_reload_hold();
    logic [31:0] d;
    do_reset();
    wr(1, 50); wr(2, 32'h4755); wr(3, 32'h1);
    tb_tick(2);
    wr(1, 9); rd(0, d); chk("R3 reload no effect", d, 48);
    wr(2, 32'h4755); rd(0, d); chk("R3 reload after key", d, 9);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    do_reset();
    wr(1, 20); wr(2, 32'h4755);
    tb_tick(3); rd(0, d); chk("R4 disabled holds", d, 20);
    wr(3, 32'h1); tb_tick(5); rd(0, d); chk("R4 counts down", d, 15);
    wr(3, 32'h0); tb_tick(4); rd(0, d); chk("R4 stop holds", d, 15);
  endtask

  task automatic t_ticksel();
    logic [31:0] d;
    do_reset();
    wr(1, 10); wr(2, 32'h4755); wr(3, 32'h11);
    tb_tick(3); rd(0, d); chk("R5 base ignored in fast", d, 10);
    tm_tick(2); rd(0, d); chk("R5 fast tick counts", d, 8);
    wr(3, 32'h01);
    tm_tick(3); rd(0, d); chk("R5 fast ignored in base", d, 8);
    tb_tick(1); rd(0, d); chk("R5 base counts", d, 7);
  endtask

  task automatic t_expire();
    logic [31:0] d;
    do_reset();
    wr(1, 2); wr(2, 32'h4755); wr(3, 32'h81);
    tb_tick(1); rd(4, d); chk("R6 no flag early", d, 0);
    tb_tick(1); rd(4, d); chk("R7 flag with boot bit", d, 3);
    tb_tick(3); rd(0, d); chk("R6 stays at zero", d, 0);
    wr(5, 32'h2); rd(4, d); chk("R6 clear bit0=0 ignored", d, 3);
    wr(5, 32'h1); rd(4, d); chk("R6 cleared", d, 0);
    chk("R8 no reset when unarmed", outs(), 0);
    wr(3, 32'h01); wr(2, 32'h4755); tb_tick(2);
    rd(4, d); chk("R7 no boot bit", d, 1);
  endtask

  task automatic t_scope(int m);
    logic [31:0] exp;
    do_reset();
    wr(6, 0); wr(7, 32'h3FF_FFFF);
    wr(1, 1); wr(2, 32'h4755); wr(3, 32'h3 | (m << 5));
    exp = (m == 0) ? 32'h1000_0000 : (m == 1) ? 32'h0800_0000 : 32'h0400_0000;
    chk("R9 idle before expiry", outs(), 0);
    tb_tick(1); chk("R9 scope pulse", outs(), exp);
    tb_tick(1); chk("R11 width0 acts as 1", outs(), 0);
  endtask

  task automatic t_mask_width();
    do_reset();
    wr(6, 3); wr(7, 32'h200_0081);
    wr(1, 1); wr(2, 32'h4755); wr(3, 32'h63);
    tb_tick(1); chk("R10 mask pulse", outs(), 32'h200_0081);
    tb_tick(1); chk("R11 width tick1", outs(), 32'h200_0081);
    tb_tick(1); chk("R11 width tick2", outs(), 32'h200_0081);
    tb_tick(1); chk("R11 width end", outs(), 0);
  endtask

  initial begin
    t_reset();
    t_key();
    t_reload_hold();
    t_enable();
    t_ticksel();
    t_expire();
    for (int m = 0; m < 3; m++) t_scope(m);
    t_mask_width();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule